// File: doc/BRIEF.md
# One-Shot Match Timer

This peripheral is a software-visible timer that counts toward a programmed target once and then stops. Software writes a target value into the match register. From the current counter value, the counter then advances by one on every cycle in which the tick-enable input is high. If the target is not ahead of the counter, the count wraps through zero first. When the counter lands on the target, it holds there and stops. If interrupts are enabled at that instant, a sticky status bit is set and the level interrupt output rises. The interrupt stays high until software writes the status register.

The block sits on a simple word-wide register bus with separate read and write strobes, a byte address and 32-bit data. Every access is a whole word. Read data is registered and appears one cycle after the read strobe. The counter width is a parameter, so a narrow counter can be built to cover wrap behaviour in few cycles. Reads zero-extend the counter to the bus width.

Top module: `oneshot_match_timer`

## Requirements
- R1: After a synchronous reset, the match, counter, status and interrupt-enable registers are zero, and irq and bus_rdata are low.
- R2: A bus write to byte offset 0x00 stores the low CNT_W bits of the data as the target and arms a count. The counter does not change in the write cycle. It advances from its current value on later ticks.
- R3: While the count is armed, the counter increases by exactly one at each clock edge where tick_en is high. It never changes at an edge where tick_en is low.
- R4: A target that is not greater than the counter is reached by counting up through all-ones and then zero. A target equal to the counter takes a full 2^CNT_W ticks.
- R5: At the tick that makes the counter equal to the target, the count disarms. The counter then keeps exactly the target value until offset 0x00 is written again.
- R6: On that tick, status bit 0 and irq are set at the same edge, but only if the interrupt-enable register (the value held before that edge) is nonzero. Otherwise no status and no interrupt are produced, and enabling interrupts later raises nothing.
- R7: Any bus write to offset 0x14 clears status and drops irq at the next edge, whatever the data. A match event in the same cycle takes priority and leaves status set.
- R8: When a write to offset 0x00 and a match event fall in the same cycle, the write wins. The new target is loaded, the count stays armed, the counter is not advanced, and status is not set.
- R9: Read data is registered and valid one cycle after bus_rd. Offset 0x10 returns the live counter, zero-extended. Offset 0x14 returns status in bit 0. Offset 0x1C returns the enable word. Offset 0x00, misaligned and unmapped offsets, and cycles without bus_rd all return zero.
- R10: Writes to offset 0x10 and to unmapped or misaligned offsets change no register.
- R11: A write to offset 0x1C stores all 32 data bits as the interrupt-enable word, and reading 0x1C returns that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick qualifier, one count step per high cycle |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, mirrors the status bit |

## Verification
A register write takes effect at the first rising edge after the strobe. Read data appears at the edge that ends the read cycle. Status and irq change at the same edge as the final counting tick, with no added delay. The bench drives every strobe and tick for exactly one cycle from a falling edge. It samples irq and the read data at the following falling edge, which is the first point where each registered result is valid. A sweep on an 8-bit counter covers every distance from 1 to 256 ticks, including the full wrap. For each distance the bench checks the counter one tick before the match, at the match, and after further ticks.

// File: rtl/otm_pkg.sv
package otm_pkg;

  localparam int unsigned BUS_W     = 32;
  localparam int unsigned OFS_MATCH = 'h00;
  localparam int unsigned OFS_COUNT = 'h10;
  localparam int unsigned OFS_STAT  = 'h14;
  localparam int unsigned OFS_IEN   = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STAT,
    SEL_IEN
  } otm_sel_e;

endpackage

// File: rtl/otm_decode.sv
module otm_decode
  import otm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output otm_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFS_MATCH))      sel = SEL_MATCH;
    else if (addr == ADDR_W'(OFS_COUNT)) sel = SEL_COUNT;
    else if (addr == ADDR_W'(OFS_STAT))  sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_IEN))   sel = SEL_IEN;
    else                                 sel = SEL_NONE;
  end

endmodule

// File: rtl/otm_counter.sv
module otm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             match_wr,
  input  logic [CNT_W-1:0] match_din,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] match_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign step    = armed_q & tick_en & ~match_wr;
  assign hit_o   = step & (cnt_nxt == match_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= '0;
      armed_q <= 1'b0;
    end else if (match_wr) begin
      match_q <= match_din;
      armed_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == match_q) armed_q <= 1'b0;
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && tick_en && !match_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R5
  hit_land_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> (cnt_q == match_q) && !armed_q);

  // R5
  idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !match_wr) |=> $stable(cnt_q) && !armed_q);

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    match_wr |=> armed_q && $stable(cnt_q));

endmodule

// File: rtl/otm_status.sv
module otm_status #(
  parameter int unsigned IEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             stat_clr,
  input  logic             ien_wr,
  input  logic [IEN_W-1:0] ien_din,
  output logic [IEN_W-1:0] ien_o,
  output logic             stat_o
);

  logic [IEN_W-1:0] ien_q;
  logic             stat_q;
  logic             fire;

  assign fire   = hit & (ien_q != '0);
  assign ien_o  = ien_q;
  assign stat_o = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (ien_wr) ien_q <= ien_din;
      if (fire)          stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end

  // R6
  fire_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && ien_q != '0) |=> stat_q);

  // R6
  stat_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $past(hit));

  // R7
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !(hit && ien_q != '0)) |=> !stat_q);

endmodule

// File: rtl/oneshot_match_timer.sv
module oneshot_match_timer
  import otm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam int unsigned PAD_W = BUS_W - CNT_W;

  otm_sel_e         sel;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic [BUS_W-1:0] ien;
  logic             stat;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;

  otm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  otm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .match_wr  (bus_wr && sel == SEL_MATCH),
    .match_din (bus_wdata[CNT_W-1:0]),
    .cnt_o     (cnt),
    .hit_o     (hit)
  );

  otm_status #(.IEN_W(BUS_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .stat_clr (bus_wr && sel == SEL_STAT),
    .ien_wr   (bus_wr && sel == SEL_IEN),
    .ien_din  (bus_wdata),
    .ien_o    (ien),
    .stat_o   (stat)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        case (sel)
          SEL_COUNT: rd_mux = {{PAD_W{1'b0}}, cnt};
          SEL_STAT:  rd_mux = {{(BUS_W-1){1'b0}}, stat};
          SEL_IEN:   rd_mux = ien;
          default:   rd_mux = '0;
        endcase
      end
    end else begin : g_full
      always_comb begin
        case (sel)
          SEL_COUNT: rd_mux = cnt[BUS_W-1:0];
          SEL_STAT:  rd_mux = {{(BUS_W-1){1'b0}}, stat};
          SEL_IEN:   rd_mux = ien;
          default:   rd_mux = '0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
  assign irq       = stat;

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  // R9
  rdata_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: tb/oneshot_match_timer_tb_top.sv
module oneshot_match_timer_tb_top;

  localparam int unsigned AW = 8;
  localparam int unsigned CW = 8;
  localparam int unsigned MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  int cnt_m = 0;

  always #10 clk = ~clk;

  oneshot_match_timer #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int m;
    int nm;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    rd('h10, d); chk("R1 counter", d, 32'h0);
    rd('h14, d); chk("R1 status", d, 32'h0);
    rd('h1C, d); chk("R1 ien", d, 32'h0);
    chk("R9 idle rdata", bus_rdata, 32'h0);

    // R11 enable word readback
    wr('h1C, 32'hA5A5_0000);
    rd('h1C, d); chk("R11 ien", d, 32'hA5A5_0000);

    // R2 R3 R4 R5 R6 R7 sweep over every distance
    for (int delta = 1; delta <= MOD; delta++) begin
      m = (cnt_m + delta) % MOD;
      wr('h00, 32'(m));
      tick(delta - 1);
      rd('h10, d); chk("R3 counter before match", d, 32'((cnt_m + delta - 1) % MOD));
      chk("R6 irq before match", {31'b0, irq}, 32'h0);
      tick(1);
      chk("R6 irq at match", {31'b0, irq}, 32'h1);
      rd('h10, d); chk("R5 counter at match", d, 32'(m));
      tick(3);
      rd('h10, d); chk("R5 counter stopped", d, 32'(m));
      rd('h14, d); chk("R6 status set", d, 32'h1);
      wr('h14, (delta % 2 == 1) ? 32'hFFFF_FFFF : 32'h0);
      chk("R7 irq cleared", {31'b0, irq}, 32'h0);
      rd('h14, d); chk("R7 status cleared", d, 32'h0);
      cnt_m = m;
    end

    // R6 no status when enable is zero
    wr('h1C, 32'h0);
    m = (cnt_m + 5) % MOD;
    wr('h00, 32'(m));
    tick(5);
    chk("R6 no irq when disabled", {31'b0, irq}, 32'h0);
    rd('h10, d); chk("R5 counter disabled match", d, 32'(m));
    wr('h1C, 32'h1);
    chk("R6 late enable no irq", {31'b0, irq}, 32'h0);
    rd('h14, d); chk("R6 status stays clear", d, 32'h0);
    cnt_m = m;

    // R3 gaps in tick_en hold the counter
    m = (cnt_m + 4) % MOD;
    wr('h00, 32'(m));
    tick(1);
    repeat (5) @(negedge clk);
    rd('h10, d); chk("R3 hold without tick", d, 32'((cnt_m + 1) % MOD));
    tick(3);
    chk("R6 irq after gapped count", {31'b0, irq}, 32'h1);
    wr('h14, 32'h0);
    cnt_m = m;

    // R10 ignored writes
    wr('h10, 32'h77);
    wr('h08, 32'h55);
    wr('h11, 32'h33);
    rd('h10, d); chk("R10 counter write ignored", d, 32'(cnt_m));
    rd('h1C, d); chk("R10 ien untouched", d, 32'h1);
    chk("R10 irq untouched", {31'b0, irq}, 32'h0);
    // R9 write-only, unmapped and misaligned reads
    rd('h00, d); chk("R9 match reads zero", d, 32'h0);
    rd('h08, d); chk("R9 unmapped reads zero", d, 32'h0);
    rd('h11, d); chk("R9 misaligned reads zero", d, 32'h0);

    // R8 match write colliding with match event
    m = (cnt_m + 3) % MOD;
    wr('h00, 32'(m));
    tick(2);
    nm = (cnt_m + 2 + 10) % MOD;
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'('h00); bus_wdata = 32'(nm);
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    chk("R8 no irq on collision", {31'b0, irq}, 32'h0);
    rd('h10, d); chk("R8 counter not advanced", d, 32'((cnt_m + 2) % MOD));
    tick(9);
    chk("R8 rearmed not yet", {31'b0, irq}, 32'h0);
    tick(1);
    chk("R8 new target reached", {31'b0, irq}, 32'h1);
    wr('h14, 32'h0);
    cnt_m = nm;

    // R7 match event beats a same-cycle status clear
    m = (cnt_m + 2) % MOD;
    wr('h00, 32'(m));
    tick(1);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'('h14); bus_wdata = 32'h0;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    chk("R7 set wins over clear", {31'b0, irq}, 32'h1);
    wr('h14, 32'h0);
    chk("R7 later clear", {31'b0, irq}, 32'h0);

    finish_run();
  end

endmodule